// File: doc/BRIEF.md
# Hibernation wakeup and reset sequencer

This block takes a system down into hibernation on a software command and brings it back up on an external wakeup request. It runs from the slow always-on clock, and every count it makes is in ticks of that clock. Software reaches three registers over a simple single-cycle bus clocked by the same clock. A write of the value 1 to the command register turns the power-enable output off and holds the system reset output low.

While hibernating, the block watches an active-low wakeup pin through a two-flop synchronizer. A wakeup is accepted only after the synchronized pin has stayed asserted for a programmable number of consecutive ticks. If the pin lets go early, the count starts again from zero. Once a wakeup is accepted, power comes back at once. The system reset stays low for a second programmable number of ticks before the block returns to normal running.

Both durations are set through register fields that keep only their upper bits. This gives the filter a granularity of 32 ticks and keeps the registers small. At reset the fields hold values that suit a 32768 Hz clock: 1952 ticks for the filter and 3264 ticks for the reset pulse.

Top module: `hib_seq`

## Requirements
- R1: After reset, pwr_en is 1 and sys_rst_n is 1. The command register (0x20) reads 0, the filter register (0x24) reads 0x07A0 and the reset-length register (0x28) reads 0x0CC0.
- R2: In the running state, a write of exactly 32'h1 to 0x20 makes pwr_en and sys_rst_n 0 from the next cycle on. While hibernating, 0x20 reads 1.
- R3: A write to 0x20 of any value other than 32'h1 has no effect: pwr_en stays 1 and 0x20 still reads 0.
- R4: The filter register keeps only write-data bits 15:5, and the reset-length register keeps only bits 11:5. All other bits read 0, and any address other than 0x20, 0x24 and 0x28 reads 0.
- R5: While hibernating, wake_n is active low and passes through two synchronizer flops. Let F be the filter value, taken as 1 when it is 0. If wake_n goes low and stays low, pwr_en rises on the (F+2)-th rising clock edge after it fell, and not before.
- R6: If wake_n returns high before the filter count is reached, the count restarts. A later assertion must again last the full F ticks.
- R7: Let R be the reset-length value, taken as 1 when it is 0. After pwr_en rises, sys_rst_n stays 0 for exactly R cycles and then returns to 1. From then on, 0x20 reads 0 again.
- R8: In the running state, wake_n has no effect on pwr_en or sys_rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wake_n | input | 1 | Asynchronous wakeup request, active low |
| pwr_en | output | 1 | Power enable; 0 while hibernating |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
If the sequencer state is wrong, it shows within one cycle at pwr_en, sys_rst_n or the command register read-back, because all three are decoded from that state. A wrong filter or reset-length counter does not show until the end of its window: pwr_en or sys_rst_n then moves one or more ticks early or late. The checks therefore sample the cycle just before each expected edge and the cycle just after it. A counter that fails to clear on a pin glitch only shows when a later assertion ends its wait too soon, so that case is driven on purpose.

// File: rtl/hib_seq.sv
module hib_seq #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int FW = 16,
  parameter int RW = 12,
  parameter int GRAN = 5,
  parameter logic [AW-1:0] A_HIB = 8'h20,
  parameter logic [AW-1:0] A_FLT = 8'h24,
  parameter logic [AW-1:0] A_RST = 8'h28,
  parameter logic [FW-1:0] FLT_DEF = 16'h07A0,
  parameter logic [RW-1:0] RST_DEF = 12'h0CC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wake_n,
  output logic          pwr_en,
  output logic          sys_rst_n
);
  localparam int FK = FW - GRAN;
  localparam int RK = RW - GRAN;

  typedef enum logic [1:0] {S_RUN, S_HIB, S_WRST} st_t;

  st_t st;
  logic [1:0] wsync;
  logic [FK-1:0] flt_q;
  logic [RK-1:0] rst_q;
  logic [FW-1:0] cnt;
  logic [RW-1:0] rcnt;

  wire [FW-1:0] flt_val = {flt_q, {GRAN{1'b0}}};
  wire [RW-1:0] rst_val = {rst_q, {GRAN{1'b0}}};
  wire wk = ~wsync[1];
  wire flt_hit = ({1'b0, cnt} + 1'b1) >= {1'b0, flt_val};
  wire rst_hit = ({1'b0, rcnt} + 1'b1) >= {1'b0, rst_val};
  wire hib_cmd = bus_we && (bus_addr == A_HIB) && (bus_wdata == DW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wsync <= 2'b11;
    else        wsync <= {wsync[0], wake_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q <= FLT_DEF[FW-1:GRAN];
      rst_q <= RST_DEF[RW-1:GRAN];
    end else if (bus_we) begin
      if (bus_addr == A_FLT) flt_q <= bus_wdata[FW-1:GRAN];
      if (bus_addr == A_RST) rst_q <= bus_wdata[RW-1:GRAN];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_RUN;
      cnt  <= '0;
      rcnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          cnt <= '0;
          if (hib_cmd) st <= S_HIB;
        end
        S_HIB: begin
          if (!wk) cnt <= '0;
          else if (flt_hit) begin
            st   <= S_WRST;
            rcnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_WRST: begin
          if (rst_hit) st <= S_RUN;
          else rcnt <= rcnt + 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end

  assign pwr_en    = (st != S_HIB);
  assign sys_rst_n = (st == S_RUN);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_HIB:   bus_rdata[0] = (st == S_HIB);
      A_FLT:   bus_rdata[FW-1:0] = flt_val;
      A_RST:   bus_rdata[RW-1:0] = rst_val;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module hib_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int FW = 16,
  parameter int RW = 12,
  parameter int GRAN = 5,
  parameter logic [AW-1:0] A_HIB = 8'h20,
  parameter logic [AW-1:0] A_FLT = 8'h24,
  parameter logic [AW-1:0] A_RST = 8'h28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          pwr_en,
  input logic          sys_rst_n,
  input logic          sync_n
);
  localparam logic [DW-1:0] FMASK = DW'(((64'd1 << FW) - 1) & ~((64'd1 << GRAN) - 1));
  localparam logic [DW-1:0] RMASK = DW'(((64'd1 << RW) - 1) & ~((64'd1 << GRAN) - 1));

  // R2
  hib_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_HIB && bus_wdata == DW'(1) && sys_rst_n) |=> !pwr_en);
  // R2
  hib_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && bus_addr == A_HIB) |-> (bus_rdata == DW'(1)));
  // R3
  hib_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_HIB && bus_wdata != DW'(1) && sys_rst_n) |=> pwr_en);
  // R4
  flt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_FLT) |-> ((bus_rdata & ~FMASK) == '0));
  // R4
  rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_RST) |-> ((bus_rdata & ~RMASK) == '0));
  // R5
  wake_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> ($past(sync_n) == 1'b0));
  // R7
  rst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !sys_rst_n);
  // R7
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(pwr_en));
endmodule

bind hib_seq hib_seq_chk #(
  .AW(AW), .DW(DW), .FW(FW), .RW(RW), .GRAN(GRAN),
  .A_HIB(A_HIB), .A_FLT(A_FLT), .A_RST(A_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en),
  .sys_rst_n(sys_rst_n), .sync_n(wsync[1])
);

// File: tb/hib_seq_bench.sv
module hib_seq_bench;
  logic clk = 0, rst_n = 0, bus_we = 0, wake_n = 1;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pwr_en, sys_rst_n;
  int n_chk = 0, n_fail = 0;
  string tq[$];
  logic [31:0] eq[$];

  always #10 clk = ~clk;

  hib_seq u_hib_seq (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_n(wake_n),
    .pwr_en(pwr_en), .sys_rst_n(sys_rst_n));

  task automatic sb_push(input string tag, input logic [31:0] exp);
    tq.push_back(tag);
    eq.push_back(exp);
  endtask

  task automatic sb_check(input logic [31:0] act);
    string tag;
    logic [31:0] exp;
    tag = tq.pop_front();
    exp = eq.pop_front();
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    edges(1);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic hibernate();
    logic [31:0] d;
    wr(8'h20, 32'h1);
    sb_push("R2 pwr_en", 0); sb_check(pwr_en);
    sb_push("R2 sys_rst_n", 0); sb_check(sys_rst_n);
    rd(8'h20, d); sb_push("R2 readback", 1); sb_check(d);
  endtask

  task automatic wake_seq(input int f, input int r);
    int fe, re;
    logic [31:0] d;
    fe = (f < 1) ? 1 : f;
    re = (r < 1) ? 1 : r;
    wake_n = 0;
    edges(fe + 1);
    sb_push("R5 before edge", 0); sb_check(pwr_en);
    edges(1);
    sb_push("R5 after edge", 1); sb_check(pwr_en);
    sb_push("R7 rst start", 0); sb_check(sys_rst_n);
    if (re > 1) begin
      edges(re - 1);
      sb_push("R7 rst last", 0); sb_check(sys_rst_n);
    end
    edges(1);
    sb_push("R7 rst release", 1); sb_check(sys_rst_n);
    rd(8'h20, d); sb_push("R7 cmd cleared", 0); sb_check(d);
    wake_n = 1;
    edges(3);
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    edges(3);
    rst_n = 1;
    edges(1);
    // R1 reset state
    sb_push("R1 pwr_en", 1); sb_check(pwr_en);
    sb_push("R1 sys_rst_n", 1); sb_check(sys_rst_n);
    rd(8'h20, d); sb_push("R1 cmd", 0); sb_check(d);
    rd(8'h24, d); sb_push("R1 filter", 32'h07A0); sb_check(d);
    rd(8'h28, d); sb_push("R1 reset len", 32'h0CC0); sb_check(d);
    edges(1);

    // R8 wake pin while running
    wake_n = 0; edges(10);
    sb_push("R8 pwr_en", 1); sb_check(pwr_en);
    sb_push("R8 sys_rst_n", 1); sb_check(sys_rst_n);
    wake_n = 1; edges(3);

    // default durations
    hibernate();
    wake_seq(32'h07A0, 32'h0CC0);

    // R3 other values ignored
    wr(8'h20, 32'h3);
    sb_push("R3 pwr_en val3", 1); sb_check(pwr_en);
    rd(8'h20, d); sb_push("R3 cmd val3", 0); sb_check(d);
    wr(8'h20, 32'h0);
    sb_push("R3 pwr_en val0", 1); sb_check(pwr_en);
    wr(8'h20, 32'h8000_0001);
    sb_push("R3 pwr_en high bit", 1); sb_check(pwr_en);

    // R4 masking
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d); sb_push("R4 filter mask", 32'hFFE0); sb_check(d);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); sb_push("R4 reset mask", 32'h0FE0); sb_check(d);
    rd(8'h2C, d); sb_push("R4 unmapped", 0); sb_check(d);
    wr(8'h24, 32'h3F);
    rd(8'h24, d); sb_push("R4 filter 32", 32'h20); sb_check(d);
    wr(8'h28, 32'h5F);
    rd(8'h28, d); sb_push("R4 reset 64", 32'h40); sb_check(d);

    hibernate();
    wake_seq(32, 64);

    // R6 glitch restarts the count
    hibernate();
    wake_n = 0; edges(20);
    wake_n = 1; edges(5);
    sb_push("R6 short pulse", 0); sb_check(pwr_en);
    wake_seq(32, 64);

    // zero fields act as one tick
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h1F);
    hibernate();
    wake_seq(0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule